// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits behind the opcode decoder of an 8-bit processor with a 64 Kbyte address space. It turns the operand bytes that follow an opcode into the 16-bit address of the operand. The decoder pulses `start` with a mode select, and samples the X and Y index registers, the program counter and the branch condition at the same time. The block then takes the operand bytes it needs, one per accepted handshake on a byte-wide stream. When the address is formed, it raises `ea_done` for one cycle.

Some modes yield no operand address: inherent instructions, and relative branches that are not taken. For these the block raises `ea_no_addr` together with `ea_done`. Address bytes are never checked for alignment, and every sum wraps modulo 65536 without any fault.

Top module: `opnd_ea_gen`

## Requirements
- R1: After synchronous reset the block is idle, with `byte_ready`, `ea_done` and `ea_no_addr` all low and `ea` at 0x0000.
- R2: `start` is taken only while idle. A `start` pulse during an operation that is still taking bytes changes neither that operation nor its result.
- R3: Inherent mode (mode code 0) takes no bytes. `ea_done` and `ea_no_addr` are high in the cycle after `start`, and `ea` reads 0x0000.
- R4: Immediate mode (code 1) takes no bytes. In the cycle after `start`, `ea_done` is high and `ea` equals the sampled `pc`.
- R5: Direct mode (code 2) takes one byte. `ea` has that byte as its low byte and 0x00 as its high byte.
- R6: Extended mode (code 3) takes two bytes. The first byte is the high byte of `ea` and the second is the low byte.
- R7: Indexed modes (code 4 uses X, code 5 uses Y) take one byte. They add it as an unsigned value to the sampled index register, modulo 65536.
- R8: Relative mode (code 6) with the branch taken takes one byte. `ea` = `pc` + 1 + the byte read as a signed value, modulo 65536. Here `pc` is the address of the offset byte.
- R9: Relative mode with the branch not taken still takes its byte. It then raises `ea_done` with `ea_no_addr` set.
- R10: `byte_ready` is high only while bytes are still owed. A byte offered while `byte_ready` is low is not taken. Gaps in `byte_valid` only delay completion.
- R11: `ea_done` is high for exactly the cycle after the final byte is taken, or the cycle after `start` for modes with no bytes. `ea` and `ea_no_addr` hold their values until the next completion.
- R12: Mode code 7 behaves exactly like inherent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an address computation (taken when idle) |
| mode | input | 3 | Addressing mode code |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| pc | input | 16 | Address of the first byte after the opcode |
| br_taken | input | 1 | Branch condition for relative mode |
| byte_valid | input | 1 | Operand byte offered |
| byte_data | input | 8 | Operand byte |
| byte_ready | output | 1 | Block is waiting for an operand byte |
| ea | output | 16 | Effective address |
| ea_done | output | 1 | One-cycle completion strobe |
| ea_no_addr | output | 1 | Completion carries no address |

## Verification
The bench builds the block with its default widths: a 16-bit address and 8-bit operand bytes, so extended mode takes two bytes. At these widths, carries out of bit 15 can be reached directly: indexed sums from near 0xFFFF, and relative targets on both sides of zero. The offset byte's sign bit is bit 7, so 0x7F and 0xFE exercise the largest forward offset and a backward one. The directed tests also cover stalls between bytes, bytes offered while idle, and a `start` pulse in the middle of an extended fetch.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    EA_INH = 3'd0,
    EA_IMM = 3'd1,
    EA_DIR = 3'd2,
    EA_EXT = 3'd3,
    EA_IDX = 3'd4,
    EA_IDY = 3'd5,
    EA_REL = 3'd6,
    EA_RSV = 3'd7
  } ea_mode_e;

endpackage

// File: rtl/ea_seq.sv
// Byte-count sequencer: owns the idle/busy state and the handshake.
module ea_seq #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] need,
  input  logic          byte_valid,
  output logic          byte_ready,
  output logic          begin_op,
  output logic          zero_done,
  output logic          take,
  output logic          last_take
);

  logic          busy_q;
  logic [CW-1:0] left_q;

  assign byte_ready = busy_q;
  assign begin_op   = !busy_q && start;
  assign zero_done  = begin_op && (need == '0);
  assign take       = busy_q && byte_valid;
  assign last_take  = take && (left_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (begin_op && (need != '0)) begin
      busy_q <= 1'b1;
      left_q <= need;
    end else if (take) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  // R10: an operation that owes bytes opens the stream on the next cycle
  assert_ready_after_begin_R10: assert property (@(posedge clk) disable iff (rst)
    (begin_op && (need != '0)) |=> byte_ready);

  // R2: a start seen while busy does not disturb the owed count
  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_ready && start && !byte_valid) |=> (byte_ready && $stable(left_q)));

endmodule

// File: rtl/ea_calc.sv
// Pure address arithmetic for every mode.
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  ea_mode_e        mode,
  input  logic [AW-1:0]   x,
  input  logic [AW-1:0]   y,
  input  logic [AW-1:0]   pc,
  input  logic            br,
  input  logic [DW-1:0]   lo_byte,
  input  logic [AW-1:0]   assembled,
  output logic [AW-1:0]   ea_c,
  output logic            na_c
);

  localparam int XW = AW - DW;

  function automatic logic [AW-1:0] add_unsigned(input logic [AW-1:0] base,
                                                 input logic [DW-1:0] off);
    return base + {{XW{1'b0}}, off};
  endfunction

  function automatic logic [AW-1:0] add_branch(input logic [AW-1:0] base,
                                               input logic [DW-1:0] off);
    return base + AW'(1) + {{XW{off[DW-1]}}, off};
  endfunction

  always_comb begin
    ea_c = '0;
    na_c = 1'b0;
    unique case (mode)
      EA_IMM: ea_c = pc;
      EA_DIR: ea_c = {{XW{1'b0}}, lo_byte};
      EA_EXT: ea_c = assembled;
      EA_IDX: ea_c = add_unsigned(x, lo_byte);
      EA_IDY: ea_c = add_unsigned(y, lo_byte);
      EA_REL: begin
        ea_c = br ? add_branch(pc, lo_byte) : '0;
        na_c = !br;
      end
      default: na_c = 1'b1;
    endcase
  end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] idx_x,
  input  logic [AW-1:0] idx_y,
  input  logic [AW-1:0] pc,
  input  logic          br_taken,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_data,
  output logic          byte_ready,
  output logic [AW-1:0] ea,
  output logic          ea_done,
  output logic          ea_no_addr
);

  localparam int NB = AW / DW;
  localparam int CW = $clog2(NB + 1);

  ea_mode_e         mode_in, mode_q, mode_c;
  logic [AW-1:0]    x_q, y_q, pc_q, pc_c;
  logic             br_q, br_c;
  logic [AW-DW-1:0] asm_q;
  logic [AW-1:0]    asm_full;
  logic [CW-1:0]    need;
  logic             begin_op, zero_done, take, last_take;
  logic [AW-1:0]    ea_c;
  logic             na_c;
  logic [AW-1:0]    ea_q;
  logic             done_q, na_q;

  assign mode_in = ea_mode_e'(mode);

  always_comb begin
    unique case (mode_in)
      EA_DIR, EA_IDX, EA_IDY, EA_REL: need = CW'(1);
      EA_EXT:                         need = CW'(NB);
      default:                        need = '0;
    endcase
  end

  ea_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .need       (need),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .begin_op   (begin_op),
    .zero_done  (zero_done),
    .take       (take),
    .last_take  (last_take)
  );

  assign asm_full = {asm_q, byte_data};
  assign mode_c   = begin_op ? mode_in : mode_q;
  assign pc_c     = begin_op ? pc : pc_q;
  assign br_c     = begin_op ? br_taken : br_q;

  ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode      (mode_c),
    .x         (x_q),
    .y         (y_q),
    .pc        (pc_c),
    .br        (br_c),
    .lo_byte   (byte_data),
    .assembled (asm_full),
    .ea_c      (ea_c),
    .na_c      (na_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= EA_INH;
      x_q    <= '0;
      y_q    <= '0;
      pc_q   <= '0;
      br_q   <= 1'b0;
      asm_q  <= '0;
      ea_q   <= '0;
      done_q <= 1'b0;
      na_q   <= 1'b0;
    end else begin
      if (begin_op) begin
        mode_q <= mode_in;
        x_q    <= idx_x;
        y_q    <= idx_y;
        pc_q   <= pc;
        br_q   <= br_taken;
      end
      if (take) asm_q <= asm_full[AW-DW-1:0];
      done_q <= zero_done || last_take;
      if (zero_done || last_take) begin
        ea_q <= ea_c;
        na_q <= na_c;
      end
    end
  end

  assign ea         = ea_q;
  assign ea_done    = done_q;
  assign ea_no_addr = na_q;

  // R3, R12: no-byte, no-address modes finish in one cycle with the flag set
  assert_inherent_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (begin_op && (mode_in == EA_INH || mode_in == EA_RSV)) |=> (ea_done && ea_no_addr));

  // R5: direct mode clears the high byte
  assert_direct_zero_page_R5: assert property (@(posedge clk) disable iff (rst)
    (last_take && mode_q == EA_DIR) |=> (ea_done && ea[AW-1:DW] == '0 && !ea_no_addr));

  // R9: untaken branch still completes, without an address
  assert_rel_untaken_R9: assert property (@(posedge clk) disable iff (rst)
    (last_take && mode_q == EA_REL && !br_q) |=> (ea_done && ea_no_addr));

  // R11: results hold between completions
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!zero_done && !last_take) |=> ($stable(ea) && $stable(ea_no_addr) && !ea_done));

endmodule

// File: tb/test_opnd_ea_gen.sv
`timescale 1ns/1ps
module test_opnd_ea_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  mode;
  logic [15:0] idx_x, idx_y, pc;
  logic        br_taken;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready;
  logic [15:0] ea;
  logic        ea_done, ea_no_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  opnd_ea_gen i_opnd_ea_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .br_taken(br_taken),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .ea(ea), .ea_done(ea_done), .ea_no_addr(ea_no_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected results computed in the bench's own terms
  function automatic logic [15:0] rel_target(input logic [15:0] p, input logic [7:0] o);
    int s;
    s = (o > 8'd127) ? int'(o) - 256 : int'(o);
    return 16'((int'(p) + 1 + s + 65536) % 65536);
  endfunction

  task automatic begin_op(input logic [2:0] m, input logic [15:0] p,
                          input logic [15:0] x, input logic [15:0] y, input logic b);
    @(negedge clk);
    start = 1'b1; mode = m; pc = p; idx_x = x; idx_y = y; br_taken = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic give(input string req, input logic [7:0] d);
    check(req, byte_ready, 1'b1);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic expect_done(input string req, input logic [15:0] e, input logic na);
    check({req, " done"}, ea_done, 1'b1);
    check({req, " ea"}, ea, e);
    check({req, " no_addr"}, ea_no_addr, na);
    check({req, " ready"}, byte_ready, 1'b0);
    @(negedge clk);
    check({req, " pulse"}, ea_done, 1'b0);
    check({req, " hold"}, ea, e);
  endtask

  task automatic t_reset;
    check("R1 ready", byte_ready, 1'b0);
    check("R1 done", ea_done, 1'b0);
    check("R1 no_addr", ea_no_addr, 1'b0);
    check("R1 ea", ea, 16'h0000);
  endtask

  task automatic t_inherent;
    begin_op(3'd0, 16'h1234, 16'h0, 16'h0, 1'b0);
    expect_done("R3", 16'h0000, 1'b1);
  endtask

  task automatic t_reserved;
    begin_op(3'd7, 16'h4444, 16'h0, 16'h0, 1'b1);
    expect_done("R12", 16'h0000, 1'b1);
  endtask

  task automatic t_immediate;
    begin_op(3'd1, 16'hC0DE, 16'h0, 16'h0, 1'b0);
    expect_done("R4", 16'hC0DE, 1'b0);
  endtask

  task automatic t_direct;
    begin_op(3'd2, 16'h8000, 16'h0, 16'h0, 1'b0);
    give("R5", 8'hA7);
    expect_done("R5", 16'h00A7, 1'b0);
  endtask

  task automatic t_extended_stall;
    begin_op(3'd3, 16'h0100, 16'h0, 16'h0, 1'b0);
    give("R6", 8'hBE);
    repeat (3) @(negedge clk);
    check("R10 stall ready", byte_ready, 1'b1);
    check("R10 stall done", ea_done, 1'b0);
    give("R6", 8'hEF);
    expect_done("R6", 16'hBEEF, 1'b0);
  endtask

  task automatic t_start_midway;
    begin_op(3'd3, 16'h0200, 16'h0, 16'h0, 1'b0);
    give("R2", 8'h12);
    start = 1'b1; mode = 3'd0;
    @(negedge clk);
    start = 1'b0;
    check("R2 no done", ea_done, 1'b0);
    give("R2", 8'h34);
    expect_done("R2", 16'h1234, 1'b0);
  endtask

  task automatic t_indexed;
    begin_op(3'd4, 16'h0, 16'h1000, 16'h5000, 1'b0);
    give("R7", 8'hFF);
    expect_done("R7 X", 16'h10FF, 1'b0);
    begin_op(3'd5, 16'h0, 16'h1000, 16'h5000, 1'b0);
    give("R7", 8'h80);
    expect_done("R7 Y", 16'h5080, 1'b0);
    begin_op(3'd4, 16'h0, 16'hFFF0, 16'h0, 1'b0);
    give("R7", 8'h20);
    expect_done("R7 wrap", 16'h0010, 1'b0);
  endtask

  task automatic t_relative;
    begin_op(3'd6, 16'h2000, 16'h0, 16'h0, 1'b1);
    give("R8", 8'h7F);
    expect_done("R8 fwd", rel_target(16'h2000, 8'h7F), 1'b0);
    begin_op(3'd6, 16'h1000, 16'h0, 16'h0, 1'b1);
    give("R8", 8'hFE);
    expect_done("R8 back", rel_target(16'h1000, 8'hFE), 1'b0);
    begin_op(3'd6, 16'hFFFF, 16'h0, 16'h0, 1'b1);
    give("R8", 8'h05);
    expect_done("R8 wrap", rel_target(16'hFFFF, 8'h05), 1'b0);
    begin_op(3'd6, 16'h0000, 16'h0, 16'h0, 1'b1);
    give("R8", 8'h80);
    expect_done("R8 under", rel_target(16'h0000, 8'h80), 1'b0);
    begin_op(3'd6, 16'h3000, 16'h0, 16'h0, 1'b0);
    give("R9", 8'h10);
    expect_done("R9", 16'h0000, 1'b1);
  endtask

  task automatic t_idle_bytes;
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'h55;
    repeat (2) @(negedge clk);
    check("R10 idle ready", byte_ready, 1'b0);
    check("R10 idle done", ea_done, 1'b0);
    byte_valid = 1'b0;
    begin_op(3'd2, 16'h0, 16'h0, 16'h0, 1'b0);
    give("R10", 8'h3C);
    expect_done("R10 direct", 16'h003C, 1'b0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; mode = 3'd0; idx_x = '0; idx_y = '0; pc = '0;
    br_taken = 1'b0; byte_valid = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_inherent();
    t_immediate();
    t_direct();
    t_extended_stall();
    t_start_midway();
    t_indexed();
    t_relative();
    t_idle_bytes();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule